// File: doc/BRIEF.md
# Multi-Lane Serial Register Port

This block is the control port of a two-channel signal generator. A host drives a chip-select line, a serial clock and up to four data lanes. Each access opens with an 8-bit instruction that names a register and a direction. A fixed number of data bytes follows, and that number depends on the register. The lane width can be one bit (with two-wire or three-wire wiring), two bits or four bits. The bit order can be most-significant first or least-significant first. Both settings live in a select register that the same port writes.

Writes to the per-channel registers land in shadow copies. A rising edge on the update input copies every shadow register to the active registers, which feed the datapath through the output buses. The select register is different: it takes effect as soon as its byte completes. Its two enable bits decide which channel copies a write reaches. A read returns the active value of the lowest enabled channel. All inputs are synchronised to the system clock, so the serial clock and the update input may be asynchronous to it.

Top module: `serport`

## Requirements
- R1: After reset the select register reads 0xC0 (bit 7 enables channel 1, bit 6 enables channel 0, bits 2:1 = 00 lane mode, bit 0 = 0 MSB first), and every shadow and active register holds zero.
- R2: An access is an 8-bit instruction (bit 7 = 1 read, bits 6:0 address) followed by data of a length set by the address: 0x00 1 byte, 0x03 3 bytes, 0x04 4 bytes, 0x05 2 bytes, 0x07 2 bytes, 0x08 4 bytes, 0x09 4 bytes, and any other address 1 byte that is discarded. Further accesses may follow within one select period.
- R3: The select register's bits 2:1 pick the lane mode. 00 is 1 bit, input and output on lane 0. 01 is 1 bit, input on lane 0 and output on lane 2. 10 is 2 bits on lanes 1:0. 11 is 4 bits on lanes 3:0. Within one clock, the higher lane carries the higher-numbered bit.
- R4: Bit 0 of the select register set to 1 sends the whole instruction and data word least-significant bit first. Set to 0, they go most-significant bit first.
- R5: A write to a channel register changes no active output until a rising edge of the update input.
- R6: A write to the select register takes effect when its last bit is captured, with no update edge, and the next access uses the new mode and order.
- R7: A channel-register write reaches the shadow copy of every channel whose enable bit is set, and no other copy.
- R8: A read drives the active value of the lowest enabled channel. Each chunk changes after a falling serial clock edge. The output enables are active only during the data phase of a read, and only on the lanes of the current mode.
- R9: Raising chip select aborts a partial access. Its data is discarded, and the next access starts with an instruction.
- R10: In modes 00, 01 and 10, a high level on lane 3 while selected returns the port to the start of an instruction. In mode 11, lane 3 is ordinary data.
- R11: When an update edge falls in the same system-clock cycle as the completion of a write, the active register takes the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock; data captured on its rising edge |
| sdio_i | input | 4 | Data lanes in |
| io_upd | input | 1 | Update input; rising edge copies shadow to active |
| sdio_o | output | 4 | Data lanes out |
| sdio_oe | output | 4 | Per-lane output enable |
| csr_o | output | 8 | Current select register |
| ch_cfr | output | 48 | Active function word, 24 bits per channel |
| ch_ftw | output | 64 | Active tuning word, 32 bits per channel |
| ch_pow | output | 32 | Active phase offset, 16 bits per channel |
| ch_rate | output | 32 | Active ramp rate, 16 bits per channel |
| ch_rise | output | 64 | Active rising delta, 32 bits per channel |
| ch_fall | output | 64 | Active falling delta, 32 bits per channel |

## Verification
Completing a write and the update edge can land in one system-clock cycle. The update input passes through the same synchroniser as the serial clock. The bench raises the update input in the very step that raises the final serial clock edge of a tuning write, so both edges are seen in one cycle. It then checks, with no further update, that the active output already shows the new word rather than the old one.

// File: rtl/serport.sv
module serport #(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sclk,
  input  logic [3:0]       sdio_i,
  input  logic             io_upd,
  output logic [3:0]       sdio_o,
  output logic [3:0]       sdio_oe,
  output logic [7:0]       csr_o,
  output logic [NCH*24-1:0] ch_cfr,
  output logic [NCH*32-1:0] ch_ftw,
  output logic [NCH*16-1:0] ch_pow,
  output logic [NCH*16-1:0] ch_rate,
  output logic [NCH*32-1:0] ch_rise,
  output logic [NCH*32-1:0] ch_fall
);
  localparam int NREG = 6;

  function automatic logic [5:0] reg_len(input logic [6:0] a);
    case (a)
      7'h03:                      reg_len = 6'd24;
      7'h04, 7'h08, 7'h09:        reg_len = 6'd32;
      7'h05, 7'h07:               reg_len = 6'd16;
      default:                    reg_len = 6'd8;
    endcase
  endfunction

  function automatic logic [2:0] reg_idx(input logic [6:0] a);
    case (a)
      7'h03:   reg_idx = 3'd0;
      7'h04:   reg_idx = 3'd1;
      7'h05:   reg_idx = 3'd2;
      7'h07:   reg_idx = 3'd3;
      7'h08:   reg_idx = 3'd4;
      7'h09:   reg_idx = 3'd5;
      default: reg_idx = 3'd7;
    endcase
  endfunction

  logic [6:0]  s1, s2;
  logic        sclk_q, upd_q;
  logic        in_data, rd;
  logic [5:0]  cnt;
  logic [6:0]  addr;
  logic [31:0] shr, osh;
  logic [3:0]  dout;
  logic [7:0]  csr;
  logic [31:0] bufr  [NCH][NREG];
  logic [31:0] actr  [NCH][NREG];
  logic [31:0] buf_n [NCH][NREG];

  wire        sel    = ~s2[0];
  wire [3:0]  lanes  = s2[5:2];
  wire        rise   = sel & s2[1] & ~sclk_q;
  wire        fall   = sel & ~s2[1] & sclk_q;
  wire        upd_e  = s2[6] & ~upd_q;
  wire [1:0]  mode   = csr[2:1];
  wire        lsb    = csr[0];
  wire [5:0]  k      = (mode == 2'b11) ? 6'd4 : (mode == 2'b10) ? 6'd2 : 6'd1;
  wire        resync = sel & lanes[3] & (mode != 2'b11);

  logic [31:0] shr_n, rv, osh_ld, osh_sh, wdata;
  logic [3:0]  chunk;
  logic [7:0]  ins_n;
  logic [5:0]  nb, nb_i;
  logic        chsel;

  always_comb begin
    case (mode)
      2'b11:   shr_n = lsb ? {lanes, shr[31:4]} : {shr[27:0], lanes};
      2'b10:   shr_n = lsb ? {lanes[1:0], shr[31:2]} : {shr[29:0], lanes[1:0]};
      default: shr_n = lsb ? {lanes[0], shr[31:1]} : {shr[30:0], lanes[0]};
    endcase
    case (mode)
      2'b11:   chunk = lsb ? osh[3:0] : osh[31:28];
      2'b10:   chunk = lsb ? {2'b00, osh[1:0]} : {2'b00, osh[31:30]};
      default: chunk = lsb ? {1'b0, osh[0], 1'b0, osh[0]} : {1'b0, osh[31], 1'b0, osh[31]};
    endcase
  end

  assign ins_n  = lsb ? shr_n[31:24] : shr_n[7:0];
  assign nb     = reg_len(addr);
  assign nb_i   = reg_len(ins_n[6:0]);
  assign wdata  = lsb ? (shr_n >> (6'd32 - nb)) : shr_n;
  assign osh_sh = lsb ? (osh >> k) : (osh << k);
  assign chsel  = (NCH > 1) && !csr[6];

  wire [5:0] cnt_n    = cnt + k;
  wire       ins_done = rise & ~resync & ~in_data & (cnt_n == 6'd8);
  wire       dat_done = rise & ~resync & in_data & (cnt_n == nb);
  wire       wr_fire  = dat_done & ~rd;
  wire [2:0] widx     = reg_idx(addr);
  wire [2:0] ridx     = reg_idx(ins_n[6:0]);

  always_comb begin
    if (ins_n[6:0] == 7'h00)       rv = {24'd0, csr};
    else if (ridx < 3'(NREG))      rv = actr[chsel ? NCH-1 : 0][ridx];
    else                           rv = 32'd0;
    osh_ld = lsb ? rv : (rv << (6'd32 - nb_i));
  end

  always_comb begin
    buf_n = bufr;
    if (wr_fire && widx < 3'(NREG))
      for (int c = 0; c < NCH; c++)
        if (csr[6+c]) buf_n[c][widx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 7'b0000001; s2 <= 7'b0000001;
      sclk_q <= 1'b0; upd_q <= 1'b0;
    end else begin
      s1 <= {io_upd, sdio_i, sclk, cs_n};
      s2 <= s1;
      sclk_q <= s2[1];
      upd_q <= s2[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_data <= 1'b0; rd <= 1'b0; cnt <= '0; addr <= '0;
      shr <= '0; osh <= '0; dout <= '0;
    end else if (!sel || resync) begin
      in_data <= 1'b0; cnt <= '0; shr <= '0;
    end else if (rise) begin
      if (ins_done) begin
        in_data <= 1'b1; cnt <= '0; shr <= '0;
        rd <= ins_n[7]; addr <= ins_n[6:0]; dout <= '0;
        if (ins_n[7]) osh <= osh_ld;
      end else if (dat_done) begin
        in_data <= 1'b0; cnt <= '0; shr <= '0;
      end else begin
        cnt <= cnt_n; shr <= shr_n;
      end
    end else if (fall && in_data && rd) begin
      dout <= chunk;
      osh  <= osh_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr <= 8'hC0;
      for (int c = 0; c < NCH; c++)
        for (int r = 0; r < NREG; r++) begin
          bufr[c][r] <= '0;
          actr[c][r] <= '0;
        end
    end else begin
      if (wr_fire && addr == 7'h00) csr <= wdata[7:0];
      bufr <= buf_n;
      if (upd_e) actr <= buf_n;
    end
  end

  logic [3:0] lane_mask;
  always_comb
    case (mode)
      2'b00:   lane_mask = 4'b0001;
      2'b01:   lane_mask = 4'b0100;
      2'b10:   lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase

  assign sdio_oe = (sel && in_data && rd) ? lane_mask : 4'b0000;
  assign sdio_o  = dout;
  assign csr_o   = csr;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_cfr [c*24 +: 24] = actr[c][0][23:0];
    assign ch_ftw [c*32 +: 32] = actr[c][1];
    assign ch_pow [c*16 +: 16] = actr[c][2][15:0];
    assign ch_rate[c*16 +: 16] = actr[c][3][15:0];
    assign ch_rise[c*32 +: 32] = actr[c][4];
    assign ch_fall[c*32 +: 32] = actr[c][5];
  end
endmodule

// File: rtl/serport_chk.sv
module serport_chk #(
  parameter int NCH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              in_data,
  input logic              rd,
  input logic              wr_fire,
  input logic              upd_e,
  input logic [1:0]        mode,
  input logic [3:0]        oe,
  input logic [7:0]        csr,
  input logic [NCH*32-1:0] ftw
);
  assert_csr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fire |=> $stable(csr));

  assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_e |=> $stable(ftw));

  assert_oe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] == 1'b0) |-> ($countones(oe) <= 1 && oe[1] == 1'b0 && oe[3] == 1'b0));

  assert_oe_dual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |-> (oe[3:2] == 2'b00));

  assert_oe_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe != 4'b0000) |-> (rd && in_data));

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !in_data);
endmodule

bind serport serport_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .in_data(in_data), .rd(rd),
  .wr_fire(wr_fire), .upd_e(upd_e), .mode(mode), .oe(sdio_oe),
  .csr(csr), .ftw(ch_ftw)
);

// File: tb/serport_tb.sv
`timescale 1ns/1ps
module serport_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, upd = 1'b0;
  logic [3:0] din = 4'h0;
  logic [3:0] sdio_o, sdio_oe;
  logic [7:0] csr_o;
  logic [47:0] ch_cfr;
  logic [63:0] ch_ftw, ch_rise, ch_fall;
  logic [31:0] ch_pow, ch_rate;

  always #2.5 clk = ~clk;

  serport u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdio_i(din),
    .io_upd(upd), .sdio_o(sdio_o), .sdio_oe(sdio_oe), .csr_o(csr_o),
    .ch_cfr(ch_cfr), .ch_ftw(ch_ftw), .ch_pow(ch_pow), .ch_rate(ch_rate),
    .ch_rise(ch_rise), .ch_fall(ch_fall)
  );

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  int b_mode = 0;
  bit b_lsb = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] got_q[$];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (got_q.size() > 0 && exp_q.size() > 0)
      chk(tag_q.pop_front(), {32'd0, got_q.pop_front()}, {32'd0, exp_q.pop_front()});
  end

  function automatic int lanes_per_clk();
    return (b_mode == 3) ? 4 : (b_mode == 2) ? 2 : 1;
  endfunction

  task automatic xfer(input logic [31:0] v, input int nbits, input bit upd_last);
    int k = lanes_per_clk();
    for (int j = 0; j < nbits / k; j++) begin
      int base = b_lsb ? k * j : nbits - k * (j + 1);
      logic [3:0] ln = 4'h0;
      for (int i = 0; i < k; i++) ln[i] = v[base + i];
      @(negedge clk); sclk = 1'b0; din = ln;
      repeat (8) @(negedge clk);
      sclk = 1'b1;
      if (upd_last && j == nbits / k - 1) upd = 1'b1;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] v, input int nbits, input bit upd_last);
    xfer({25'd0, a}, 8, 1'b0);
    xfer(v, nbits, upd_last);
  endtask

  task automatic rd_reg(input logic [6:0] a, input int nbits, input string tag,
                        input logic [31:0] expv, output logic [3:0] oe_seen);
    int k;
    logic [31:0] v = '0;
    exp_q.push_back(expv); tag_q.push_back(tag);
    xfer({25'd1 << 0, a} | 32'h80, 8, 1'b0);
    k = lanes_per_clk();
    oe_seen = 4'h0;
    for (int j = 0; j < nbits / k; j++) begin
      int base = b_lsb ? k * j : nbits - k * (j + 1);
      @(negedge clk); sclk = 1'b0; din = 4'h0;
      repeat (8) @(negedge clk);
      oe_seen = sdio_oe;
      for (int i = 0; i < k; i++) v[base + i] = (b_mode == 1) ? sdio_o[2] : sdio_o[i];
      sclk = 1'b1;
      repeat (8) @(negedge clk);
    end
    got_q.push_back(v);
  endtask

  task automatic sel_on();
    @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (4) @(negedge clk); cs_n = 1'b1; upd = 1'b0; din = 4'h0; repeat (8) @(negedge clk);
  endtask

  task automatic pulse_upd();
    @(negedge clk); upd = 1'b1; repeat (6) @(negedge clk); upd = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic set_csr(input logic [7:0] v);
    sel_on(); wr(7'h00, {24'd0, v}, 8, 1'b0); sel_off();
    b_mode = int'(v[2:1]); b_lsb = v[0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [3:0] oe;
    repeat (5) @(negedge clk); rst_n = 1'b1; repeat (5) @(negedge clk);
    chk("R1 reset select register", {56'd0, csr_o}, 64'hC0);
    chk("R1 reset tuning words", ch_ftw, 64'd0);

    sel_on(); wr(7'h04, 32'h12345678, 32, 1'b0); sel_off();
    chk("R5 tuning held before update", ch_ftw, 64'd0);
    pulse_upd();
    chk("R7 R5 both channels after update", ch_ftw, {2{32'h12345678}});

    sel_on();
    rd_reg(7'h04, 32, "R8 two-wire read of tuning word", 32'h12345678, oe);
    wr(7'h03, 32'h00ABCDEF, 24, 1'b0);
    wr(7'h07, 32'h00001234, 16, 1'b0);
    sel_off(); pulse_upd();
    chk("R2 three-byte function word", ch_cfr, {2{24'hABCDEF}});
    chk("R2 two-byte rate after it", ch_rate, {2{16'h1234}});

    set_csr(8'h80);
    chk("R6 select applies without update", {56'd0, csr_o}, 64'h80);
    sel_on(); wr(7'h05, 32'h3FFF, 16, 1'b0); sel_off(); pulse_upd();
    chk("R7 only channel 1 phase written", ch_pow, {16'h3FFF, 16'h0000});
    sel_on(); rd_reg(7'h05, 16, "R8 read from lowest enabled channel", 32'h3FFF, oe); sel_off();

    set_csr(8'h44);
    sel_on(); wr(7'h08, 32'hDEADBEEF, 32, 1'b0); sel_off(); pulse_upd();
    chk("R3 two-lane write channel 0 only", ch_rise, {32'h0, 32'hDEADBEEF});
    sel_on(); rd_reg(7'h08, 32, "R3 two-lane read", 32'hDEADBEEF, oe); sel_off();
    chk("R8 two-lane enables", {60'd0, oe}, 64'h3);

    set_csr(8'hC7);
    sel_on(); wr(7'h09, 32'h89ABCDEF, 32, 1'b0); sel_off(); pulse_upd();
    chk("R4 R10 four-lane LSB-first write with lane 3 data", ch_fall, {2{32'h89ABCDEF}});
    sel_on(); rd_reg(7'h09, 32, "R4 four-lane LSB-first read", 32'h89ABCDEF, oe); sel_off();

    set_csr(8'hC3);
    sel_on(); rd_reg(7'h09, 32, "R3 three-wire LSB-first read", 32'h89ABCDEF, oe); sel_off();
    chk("R3 three-wire drives lane 2 only", {60'd0, oe}, 64'h4);

    set_csr(8'hC0);
    chk("R6 back to default select", {56'd0, csr_o}, 64'hC0);

    sel_on(); xfer(32'h04, 8, 1'b0); xfer(32'hFFFF, 16, 1'b0); sel_off();
    sel_on(); wr(7'h05, 32'h0001, 16, 1'b0); sel_off(); pulse_upd();
    chk("R9 aborted write discarded", ch_ftw[31:0], 64'h12345678);
    chk("R9 next access framed correctly", {32'd0, ch_pow}, {32'd0, {2{16'h0001}}});

    sel_on(); xfer(32'hF, 4, 1'b0);
    @(negedge clk); din[3] = 1'b1; repeat (8) @(negedge clk); din[3] = 1'b0; repeat (8) @(negedge clk);
    wr(7'h07, 32'h5555, 16, 1'b0); sel_off(); pulse_upd();
    chk("R10 resync realigns instruction", {32'd0, ch_rate}, {32'd0, {2{16'h5555}}});

    sel_on(); wr(7'h08, 32'h01020304, 32, 1'b1); sel_off();
    chk("R11 same-cycle update commits new word", ch_rise, {2{32'h01020304}});

    sel_on(); wr(7'h02, 32'h77, 8, 1'b0); wr(7'h04, 32'hCAFEF00D, 32, 1'b0); sel_off();
    chk("R5 tuning still old before update", ch_ftw, {2{32'h12345678}});
    pulse_upd();
    chk("R2 unknown address takes one byte", ch_ftw, {2{32'hCAFEF00D}});

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule